// File: doc/BRIEF.md
# Interleaved Rate-1/2 Convolutional Encoder

This block turns a stream of information bits into a rate-1/2 convolutional code with memory 2, interleaved to degree `ILV`. Each unit delay of the base code is stretched to `ILV` clock samples. The result is `ILV` independent codes that take turns in time: accepted sample k belongs to lane `k mod ILV`, and each lane only sees its own history. Burst errors on the channel are therefore spread across separate codes.

A parameter picks between two variants:
- **Feed-forward, nonsystematic.** Both outputs are formed directly from the input bit and its history.
- **Recursive, systematic.** The first output is the information bit itself. The second output is a parity bit formed from an internal feedback register.

One chosen lane can also be held back by a fixed number of that lane's own slots. This staggers the lanes further and lines the stream up with a decoder that expects the offset.

A sample is accepted on each clock where `valid_in` is high. Its code pair appears one cycle later on `code_out`, with `valid_out` raised.

Top module: `ilv_conv_encoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `valid_out` is 0 and `code_out` is 2'b00. All history, the lane position and the delay fill are cleared.
- R2: In feed-forward mode, with x_k the k-th accepted bit and bits before the first accepted one taken as 0:
  - `code_out[0]` = x_k ^ x_(k-ILV) ^ x_(k-2·ILV)
  - `code_out[1]` = x_k ^ x_(k-2·ILV)
- R3: In recursive mode, the feedback bit is s_k = x_k ^ s_(k-ILV) ^ s_(k-2·ILV), with bits before the first accepted one taken as 0.
  - `code_out[0]` = x_k
  - `code_out[1]` = s_k ^ s_(k-2·ILV)
- R4: Lanes are independent: the pair for sample k depends only on accepted samples whose index has the same remainder modulo `ILV`.
- R5: The first accepted sample after reset is lane 0. The lane advances by one only on accepted samples and wraps from `ILV-1` to 0.
- R6: For samples of lane `DLY_LANE`, the emitted pair is the pair that lane produced `SLOTS` lane-samples earlier, i.e. for sample k - `SLOTS`·`ILV`. It is 2'b00 while that earlier sample does not exist. With `SLOTS` = 0 nothing is delayed.
- R7: `valid_out` is high exactly on the cycle after a cycle with `valid_in` high and `rst` low.
- R8: A cycle with `valid_in` low has no effect on the code:
  - `valid_out` is 0 on the next cycle;
  - `code_out` keeps its value;
  - later pairs are the same as if the idle cycle had not occurred.
- R9: Asserting `rst` mid-stream restarts coding: the next accepted sample is coded as sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Accept `bit_in` on this cycle |
| bit_in | input | 1 | Information bit |
| valid_out | output | 1 | `code_out` holds a new pair |
| code_out | output | 2 | Code pair: bit 0 is the first output, bit 1 is the second |

## Verification
The embedded assertions check three behaviours on every cycle:
- the one-cycle relation between `valid_in` and `valid_out`;
- that `code_out` holds its value across idle cycles;
- that the lane counter stays in range and wraps correctly.

In recursive mode, an assertion also checks that the systematic output equals the accepted bit on every undelayed lane.

Other behaviours only show up over many samples, so the bench's scenarios cover them by comparing against a reference model of both variants:
- the parity equations with their 2·`ILV` reach;
- lane independence;
- the zero fill and later replay of the delayed lane;
- the restart after a mid-stream reset.

// File: rtl/ilv_enc_pkg.sv
package ilv_enc_pkg;

  typedef enum logic {
    ENC_FEEDFWD   = 1'b0,
    ENC_RECURSIVE = 1'b1
  } enc_kind_e;

  // bit 0: first code output, bit 1: second code output
  typedef logic [1:0] code_pair_t;

endpackage

// File: rtl/ilv_lane_ctr.sv
module ilv_lane_ctr #(
  parameter int ILV    = 2,
  parameter int LANE_W = (ILV > 1) ? $clog2(ILV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [LANE_W-1:0] lane
);

  localparam logic [LANE_W-1:0] LAST = LANE_W'(ILV - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane <= '0;
    end else if (en) begin
      if (lane == LAST) lane <= '0;
      else              lane <= lane + 1'b1;
    end
  end

  // R5
  lane_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(lane) < ILV);

  // R5
  lane_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && lane == LAST) |=> lane == '0);

endmodule

// File: rtl/ilv_enc_core.sv
module ilv_enc_core
  import ilv_enc_pkg::*;
#(
  parameter int        ILV  = 2,
  parameter enc_kind_e KIND = ENC_FEEDFWD
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       bit_in,
  output code_pair_t pair_out
);

  localparam int HW = 2 * ILV;

  // hist[j] holds the register bit from j+1 accepted samples ago
  logic [HW-1:0] hist;
  logic          tap1;
  logic          tap2;
  logic          shift_bit;

  assign tap1 = hist[ILV-1];
  assign tap2 = hist[HW-1];

  generate
    if (KIND == ENC_RECURSIVE) begin : g_rsc
      logic fb;
      assign fb        = bit_in ^ tap1 ^ tap2;
      assign shift_bit = fb;
      assign pair_out  = {fb ^ tap2, bit_in};
    end else begin : g_nrsc
      assign shift_bit = bit_in;
      assign pair_out  = {bit_in ^ tap2, bit_in ^ tap1 ^ tap2};
    end
  endgenerate

  generate
    if (HW > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)     hist <= '0;
        else if (en) hist <= {hist[HW-2:0], shift_bit};
      end
    end else begin : g_one
      always_ff @(posedge clk) begin
        if (rst)     hist <= '0;
        else if (en) hist <= shift_bit;
      end
    end
  endgenerate

  // R8
  hist_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(hist));

endmodule

// File: rtl/ilv_lane_delay.sv
module ilv_lane_delay
  import ilv_enc_pkg::*;
#(
  parameter int ILV      = 2,
  parameter int SLOTS    = 2,
  parameter int DLY_LANE = 1,
  parameter int LANE_W   = (ILV > 1) ? $clog2(ILV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LANE_W-1:0] lane,
  input  code_pair_t        pair_in,
  output code_pair_t        pair_out
);

  generate
    if (SLOTS == 0) begin : g_bypass
      assign pair_out = pair_in;
    end else begin : g_ring
      localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
      localparam int CNT_W = $clog2(SLOTS + 1);

      code_pair_t       mem [SLOTS];
      logic [PTR_W-1:0] ptr;
      logic [CNT_W-1:0] fill;
      logic             mine;
      logic             full;

      assign mine = (int'(lane) == DLY_LANE);
      assign full = (fill == CNT_W'(SLOTS));

      // storage has no reset so it maps onto RAM; 'fill' masks stale words
      always_ff @(posedge clk) begin
        if (en && mine) mem[ptr] <= pair_in;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          ptr  <= '0;
          fill <= '0;
        end else if (en && mine) begin
          if (ptr == PTR_W'(SLOTS - 1)) ptr <= '0;
          else                          ptr <= ptr + 1'b1;
          if (!full) fill <= fill + 1'b1;
        end
      end

      assign pair_out = mine ? (full ? mem[ptr] : 2'b00) : pair_in;

      // R6
      fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= SLOTS);

      // R6
      fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en || !mine) |=> $stable(fill) && $stable(ptr));
    end
  endgenerate

endmodule

// File: rtl/ilv_conv_encoder.sv
module ilv_conv_encoder
  import ilv_enc_pkg::*;
#(
  parameter int        ILV      = 2,
  parameter int        SLOTS    = 2,
  parameter int        DLY_LANE = 1,
  parameter enc_kind_e KIND     = ENC_FEEDFWD
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       valid_in,
  input  logic       bit_in,
  output logic       valid_out,
  output logic [1:0] code_out
);

  localparam int LANE_W = (ILV > 1) ? $clog2(ILV) : 1;

  logic [LANE_W-1:0] lane;
  code_pair_t        raw_pair;
  code_pair_t        dly_pair;

  ilv_lane_ctr #(.ILV(ILV), .LANE_W(LANE_W)) u_lane (
    .clk  (clk),
    .rst  (rst),
    .en   (valid_in),
    .lane (lane)
  );

  ilv_enc_core #(.ILV(ILV), .KIND(KIND)) u_core (
    .clk      (clk),
    .rst      (rst),
    .en       (valid_in),
    .bit_in   (bit_in),
    .pair_out (raw_pair)
  );

  ilv_lane_delay #(
    .ILV(ILV), .SLOTS(SLOTS), .DLY_LANE(DLY_LANE), .LANE_W(LANE_W)
  ) u_dly (
    .clk      (clk),
    .rst      (rst),
    .en       (valid_in),
    .lane     (lane),
    .pair_in  (raw_pair),
    .pair_out (dly_pair)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      code_out  <= 2'b00;
    end else begin
      valid_out <= valid_in;
      if (valid_in) code_out <= dly_pair;
    end
  end

  // R7
  vout_rise_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  // R7
  vout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(code_out));

  generate
    if (KIND == ENC_RECURSIVE) begin : g_sys_chk
      // R3
      systematic_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && (SLOTS == 0 || int'(lane) != DLY_LANE))
          |=> code_out[0] == $past(bit_in));
    end
  endgenerate

endmodule

// File: tb/ilv_conv_encoder_bench.sv
module ilv_conv_encoder_bench;
  import ilv_enc_pkg::*;

  localparam int ILV   = 2;
  localparam int SLOTS = 2;
  localparam int DLANE = 1;
  localparam int NVEC  = 24;
  localparam int MAXS  = 1024;

  // stimulus table: {valid, bit}
  localparam logic [1:0] VEC [NVEC] = '{
    2'b11, 2'b10, 2'b11, 2'b11, 2'b00, 2'b10, 2'b11, 2'b10,
    2'b01, 2'b11, 2'b11, 2'b10, 2'b10, 2'b11, 2'b00, 2'b01,
    2'b11, 2'b10, 2'b11, 2'b11, 2'b10, 2'b10, 2'b11, 2'b11
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       valid_in = 1'b0;
  logic       bit_in = 1'b0;
  logic       vo_f, vo_r;
  logic [1:0] co_f, co_r;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;
  int  n     = 0;
  bit  xs [MAXS];
  bit  ss [MAXS];
  logic [1:0] prev_f = 2'b00;
  logic [1:0] prev_r = 2'b00;

  always #4 clk = ~clk;

  ilv_conv_encoder #(.ILV(ILV), .SLOTS(SLOTS), .DLY_LANE(DLANE),
                     .KIND(ENC_FEEDFWD)) u_ilv_conv_encoder (
    .clk(clk), .rst(rst), .valid_in(valid_in), .bit_in(bit_in),
    .valid_out(vo_f), .code_out(co_f));

  ilv_conv_encoder #(.ILV(ILV), .SLOTS(SLOTS), .DLY_LANE(DLANE),
                     .KIND(ENC_RECURSIVE)) u_ilv_conv_encoder_rsc (
    .clk(clk), .rst(rst), .valid_in(valid_in), .bit_in(bit_in),
    .valid_out(vo_r), .code_out(co_r));

  function automatic bit xat(int k);
    return (k >= 0) ? xs[k] : 1'b0;
  endfunction

  function automatic bit sat(int k);
    return (k >= 0) ? ss[k] : 1'b0;
  endfunction

  // undelayed pair for sample k (R2, R3)
  function automatic logic [1:0] raw_pair(bit rsc, int k);
    if (k < 0) return 2'b00;
    if (rsc) return {sat(k) ^ sat(k - 2*ILV), xat(k)};
    return {xat(k) ^ xat(k - 2*ILV), xat(k) ^ xat(k - ILV) ^ xat(k - 2*ILV)};
  endfunction

  // R6: delayed lane replays the pair SLOTS lane-samples back
  function automatic logic [1:0] exp_pair(bit rsc, int k);
    if ((k % ILV) == DLANE) return raw_pair(rsc, k - SLOTS*ILV);
    return raw_pair(rsc, k);
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (sample %0d)", req, act, exp, n);
    end
  endtask

  task automatic step(input logic v, input logic b, input string req);
    logic [1:0] ef, er;
    @(negedge clk);
    valid_in = v;
    bit_in   = b;
    @(posedge clk);
    #1;
    if (v) begin
      xs[n] = b;
      ss[n] = b ^ sat(n - ILV) ^ sat(n - 2*ILV);
      ef = exp_pair(1'b0, n);
      er = exp_pair(1'b1, n);
      check("R7", {vo_r, vo_f}, 2'b11);
      check(req, co_f, ef);
      check((req == "R2") ? "R3" : req, co_r, er);
      prev_f = ef;
      prev_r = er;
      n++;
    end else begin
      check("R8", {vo_r, vo_f}, 2'b00);
      check("R8", co_f, prev_f);
      check("R8", co_r, prev_r);
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    valid_in = 1'b1;
    bit_in = 1'b1;
    repeat (cycles) @(posedge clk);
    #1;
    check("R1", {vo_r, vo_f}, 2'b00);
    check("R1", co_f, 2'b00);
    check("R1", co_r, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    valid_in = 1'b0;
    n = 0;
    prev_f = 2'b00;
    prev_r = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset(3);
    // R1: first cycle after reset stays quiet with no input
    step(1'b0, 1'b0, "R1");

    // vector table walk, main equations with idle gaps (R2, R3, R8)
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][1], VEC[i][0], VEC[i][1] ? "R2" : "R8");
    end

    // R9: mid-stream reset restarts coding at sample 0
    do_reset(2);
    step(1'b1, 1'b1, "R9");
    step(1'b1, 1'b0, "R9");

    // R4: lane 0 carries ones, lane 1 zeros
    do_reset(1);
    for (int i = 0; i < 16; i++) begin
      step(1'b1, (i % 2) == 0, "R4");
    end

    // R5: idle cycles between samples must not advance the lane
    do_reset(1);
    for (int i = 0; i < 12; i++) begin
      step(1'b1, (i % 3) != 1, "R5");
      if (i % 4 == 1) step(1'b0, 1'b1, "R5");
    end

    // R6: all ones burst, delayed lane zero until filled then replays
    do_reset(1);
    for (int i = 0; i < 2*SLOTS*ILV + 6; i++) begin
      step(1'b1, 1'b1, "R6");
    end

    // long pseudo-random pattern with occasional gaps (R2, R3)
    do_reset(1);
    for (int i = 0; i < 200; i++) begin
      step((i % 7) != 3, ((i * 13 + i / 5) % 3) == 0, "R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule